// File: doc/BRIEF.md
# Region-Paged Virtual Address Translator

This block turns 32-bit virtual addresses into physical addresses for a machine whose address space is cut into two per-process regions and one shared system region, each 1 GB wide (a 21-bit page number over 512-byte pages). An eight-entry fully associative TLB answers repeat lookups without memory traffic. On a miss the block walks a flat, length-bounded page table through a single-beat read port. The system table is located by a physical base address. A process table lives in system virtual space, so its entry address is first translated through the system table. This gives a nested two-read walk.

A privileged caller may ask for untranslated access, in which the address is forwarded unchanged. Software programs the region bases and lengths through a small write port. A flush input discards process translations on a context switch and keeps system translations. Only one translation is in flight at a time. Each one ends in exactly one response that carries either a physical address or a fault code together with the virtual address that caused it.

Top module: `region_xlate`

## Requirements
- R1: A request with `req_untrans` and `req_priv` both set returns fault 0 and `rsp_addr` equal to `req_vaddr`, with `rsp_valid` high in the second cycle after acceptance and no memory read. This holds whatever the region bits are.
- R2: A request with `req_untrans` set and `req_priv` clear returns fault 4 (protection) with `rsp_addr` equal to the request address.
- R3: Address bits [31:30] select the region: 0 is process region A, 1 is process region B, 2 is system, and 3 is reserved. A translated request to region 3 returns fault 3 (access) with no memory read.
- R4: A page number (bits [29:9]) at or above its region's length register returns fault 1 (length), reporting the request address, with no memory read.
- R5: A system-region miss makes one read at system base + 4×page. A PTE has its valid bit at 31 and its frame number at [20:0]. The result is {2'b00, frame, va[8:0]}.
- R6: A process-region miss forms the entry address base + 4×page. If that address is not in the system region, the block returns fault 3 with that address. If its system page is at or above the system length, the block returns fault 1 with that address. Otherwise the block reads the system PTE at system base + 4×(its page), then reads the process PTE at {2'b00, system frame, entry address[8:0]}.
- R7: An invalid PTE at either level returns fault 2 (page). The reported address is the process entry address for the system-level entry and the request address for the final entry.
- R8: A TLB hit returns the same physical address as the walk would, with no memory read.
- R9: The TLB keeps eight entries replaced round-robin, so after nine distinct fills the oldest fill misses and the eight most recent fills hit.
- R10: `tlb_flush` invalidates process-region entries and keeps system-region entries.
- R11: All 21 frame bits pass to physical address bits [29:9], including bit 20.
- R12: A memory request stays asserted with a stable address until accepted. `req_ready` is low from acceptance until the response, and `rsp_valid` is a single-cycle pulse.
- R13: Configuration writes with `cfg_sel` 0/1 set region A base/length, 2/3 set region B base/length, and 4/5 set system base/length. Selects 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_untrans | input | 1 | Ask for untranslated pass-through |
| req_priv | input | 1 | Caller is privileged |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 32 | Physical address, or faulting virtual address |
| rsp_fault | output | 3 | 0 none, 1 length, 2 page, 3 access, 4 protection |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| tlb_flush | input | 1 | Discard process-region TLB entries |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Physical address of the table read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Read data (PTE) |

## Verification
System-region pages are swept across the whole programmed length and past it. This separates valid walks, invalid system entries and length faults. Process-region pages are swept so that their table entries fall into a valid system page, an invalid system page, beyond the system length, and outside system space. This tells the nested walk's faults apart from faults in the final entry. A nine-fill sequence followed by hit/miss probes, and a flush between a system fill and a process fill, expose the replacement order and the flush selectivity through the number of memory reads. Untranslated requests with and without privilege, and the reserved region, complete the fault codes.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int VA_W    = 32;
    localparam int OFF_W   = 9;
    localparam int VPN_W   = 21;
    localparam int PFN_W   = 21;
    localparam int VLD_BIT = 31;

    typedef enum logic [1:0] {
        RG_P0  = 2'd0,
        RG_P1  = 2'd1,
        RG_SYS = 2'd2,
        RG_RSV = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_LEN    = 3'd1,
        FLT_PAGE   = 3'd2,
        FLT_ACCESS = 3'd3,
        FLT_PROT   = 3'd4
    } fault_e;

    typedef struct packed {
        logic             valid;
        region_e          region;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } tlb_entry_t;

    function automatic region_e va_region(input logic [VA_W-1:0] va);
        return region_e'(va[VA_W-1 -: 2]);
    endfunction

    function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
        return va[OFF_W +: VPN_W];
    endfunction

    function automatic logic [VA_W-1:0] entry_addr(input logic [VA_W-1:0] base,
                                                   input logic [VPN_W-1:0] vpn);
        return base + {{(VA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
    endfunction

    function automatic logic [VA_W-1:0] phys_of(input logic [PFN_W-1:0] pfn,
                                                input logic [OFF_W-1:0] off);
        return {{(VA_W-PFN_W-OFF_W){1'b0}}, pfn, off};
    endfunction
endpackage

// File: rtl/xlt_regs.sv
module xlt_regs
    import xlt_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [2:0]      sel,
    input  logic [VA_W-1:0] wdata,
    input  region_e         rd_region,
    output logic [VA_W-1:0] rd_base,
    output logic [VA_W-1:0] rd_len,
    output logic [VA_W-1:0] sys_base,
    output logic [VA_W-1:0] sys_len
);
    localparam int NREG = 3;

    logic [VA_W-1:0] base_r [NREG];
    logic [VA_W-1:0] len_r  [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                base_r[i] <= '0;
                len_r[i]  <= '0;
            end
        end else if (we && sel[2:1] != 2'd3) begin
            if (sel[0]) len_r[sel[2:1]]  <= wdata;
            else        base_r[sel[2:1]] <= wdata;
        end
    end

    always_comb begin
        rd_base = '0;
        rd_len  = '0;
        if (rd_region != RG_RSV) begin
            rd_base = base_r[rd_region];
            rd_len  = len_r[rd_region];
        end
    end

    assign sys_base = base_r[RG_SYS];
    assign sys_len  = len_r[RG_SYS];
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
    import xlt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  region_e          lk_region,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PFN_W-1:0] lk_pfn,
    input  logic             fill_en,
    input  region_e          fill_region,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    tlb_entry_t      ent [ENTRIES];
    logic [IW-1:0]   victim;
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent[g].valid && ent[g].region == lk_region && ent[g].vpn == lk_vpn;
    end

    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (match[i]) lk_pfn = lk_pfn | ent[i].pfn;
    end
    assign lk_hit = |match;

    always_ff @(posedge clk) begin
        if (rst) begin
            victim <= '0;
            for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
        end else begin
            if (flush) begin
                for (int i = 0; i < ENTRIES; i++)
                    if (ent[i].region != RG_SYS) ent[i].valid <= 1'b0;
            end
            if (fill_en) begin
                ent[victim] <= '{valid: 1'b1, region: fill_region, vpn: fill_vpn, pfn: fill_pfn};
                victim      <= (victim == IW'(ENTRIES-1)) ? '0 : victim + 1'b1;
            end
        end
    end
endmodule

// File: rtl/region_xlate.sv
module region_xlate
    import xlt_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_vaddr,
    input  logic        req_untrans,
    input  logic        req_priv,
    output logic        rsp_valid,
    output logic [31:0] rsp_addr,
    output logic [2:0]  rsp_fault,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        tlb_flush,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_SREQ, ST_SWAIT, ST_LREQ, ST_LWAIT
    } state_e;

    state_e            state;
    logic [VA_W-1:0]   va_q, ptva_q, walk_q;
    logic              ut_q, pv_q;
    logic              rsp_valid_q;
    logic [VA_W-1:0]   rsp_addr_q;
    fault_e            rsp_fault_q;

    region_e           rg;
    logic [VPN_W-1:0]  vpn, svpn;
    logic [VA_W-1:0]   rg_base, rg_len, sys_base, sys_len, ptva;
    logic              tlb_hit;
    logic [PFN_W-1:0]  tlb_pfn, pte_pfn;
    logic              pte_ok, fill_en;
    logic              unused_pte_bits;

    assign rg      = va_region(va_q);
    assign vpn     = va_vpn(va_q);
    assign ptva    = entry_addr(rg_base, vpn);
    assign svpn    = va_vpn(ptva);
    assign pte_ok  = mem_rsp_data[VLD_BIT];
    assign pte_pfn = mem_rsp_data[PFN_W-1:0];
    assign unused_pte_bits = ^mem_rsp_data[VLD_BIT-1:PFN_W];
    assign fill_en = (state == ST_LWAIT) && mem_rsp_valid && pte_ok;

    xlt_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .rd_region(rg), .rd_base(rg_base), .rd_len(rg_len),
        .sys_base(sys_base), .sys_len(sys_len)
    );

    xlt_tlb #(.ENTRIES(TLB_ENTRIES)) u_tlb (
        .clk(clk), .rst(rst),
        .lk_region(rg), .lk_vpn(vpn), .lk_hit(tlb_hit), .lk_pfn(tlb_pfn),
        .fill_en(fill_en), .fill_region(rg), .fill_vpn(vpn), .fill_pfn(pte_pfn),
        .flush(tlb_flush)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            va_q        <= '0;
            ptva_q      <= '0;
            walk_q      <= '0;
            ut_q        <= 1'b0;
            pv_q        <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_addr_q  <= '0;
            rsp_fault_q <= FLT_NONE;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q  <= req_vaddr;
                    ut_q  <= req_untrans;
                    pv_q  <= req_priv;
                    state <= ST_CHECK;
                end
                ST_CHECK: begin
                    state       <= ST_IDLE;
                    rsp_valid_q <= 1'b1;
                    rsp_addr_q  <= va_q;
                    rsp_fault_q <= FLT_NONE;
                    if (ut_q) begin
                        if (!pv_q) rsp_fault_q <= FLT_PROT;
                    end else if (rg == RG_RSV) begin
                        rsp_fault_q <= FLT_ACCESS;
                    end else if ({{(VA_W-VPN_W){1'b0}}, vpn} >= rg_len) begin
                        rsp_fault_q <= FLT_LEN;
                    end else if (tlb_hit) begin
                        rsp_addr_q  <= phys_of(tlb_pfn, va_q[OFF_W-1:0]);
                    end else if (rg == RG_SYS) begin
                        rsp_valid_q <= 1'b0;
                        walk_q      <= entry_addr(sys_base, vpn);
                        state       <= ST_LREQ;
                    end else if (va_region(ptva) != RG_SYS) begin
                        rsp_fault_q <= FLT_ACCESS;
                        rsp_addr_q  <= ptva;
                    end else if ({{(VA_W-VPN_W){1'b0}}, svpn} >= sys_len) begin
                        rsp_fault_q <= FLT_LEN;
                        rsp_addr_q  <= ptva;
                    end else begin
                        rsp_valid_q <= 1'b0;
                        ptva_q      <= ptva;
                        walk_q      <= entry_addr(sys_base, svpn);
                        state       <= ST_SREQ;
                    end
                end
                ST_SREQ: if (mem_req_ready) state <= ST_SWAIT;
                ST_SWAIT: if (mem_rsp_valid) begin
                    if (!pte_ok) begin
                        rsp_valid_q <= 1'b1;
                        rsp_fault_q <= FLT_PAGE;
                        rsp_addr_q  <= ptva_q;
                        state       <= ST_IDLE;
                    end else begin
                        walk_q <= phys_of(pte_pfn, ptva_q[OFF_W-1:0]);
                        state  <= ST_LREQ;
                    end
                end
                ST_LREQ: if (mem_req_ready) state <= ST_LWAIT;
                ST_LWAIT: if (mem_rsp_valid) begin
                    rsp_valid_q <= 1'b1;
                    state       <= ST_IDLE;
                    if (!pte_ok) begin
                        rsp_fault_q <= FLT_PAGE;
                        rsp_addr_q  <= va_q;
                    end else begin
                        rsp_fault_q <= FLT_NONE;
                        rsp_addr_q  <= phys_of(pte_pfn, va_q[OFF_W-1:0]);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_SREQ) || (state == ST_LREQ);
    assign mem_req_addr  = walk_q;
    assign rsp_valid     = rsp_valid_q;
    assign rsp_addr      = rsp_addr_q;
    assign rsp_fault     = rsp_fault_q;
endmodule

// File: rtl/xlt_checker.sv
module xlt_checker
    import xlt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_untrans,
    input logic        req_priv,
    input logic        rsp_valid,
    input logic [31:0] rsp_addr,
    input logic [2:0]  rsp_fault,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr
);
    logic        acc;
    logic [31:0] cap_va;
    logic        cap_ut;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_va <= '0;
            cap_ut <= 1'b0;
        end else if (acc) begin
            cap_va <= req_vaddr;
            cap_ut <= req_untrans;
        end
    end

    p_pass_r1: assert property (@(posedge clk) disable iff (rst)
        acc && req_untrans && req_priv |=> ##1
        (rsp_valid && rsp_fault == FLT_NONE && rsp_addr == $past(req_vaddr, 2)));

    p_prot_r2: assert property (@(posedge clk) disable iff (rst)
        acc && req_untrans && !req_priv |=> ##1 (rsp_valid && rsp_fault == FLT_PROT));

    p_reserved_r3: assert property (@(posedge clk) disable iff (rst)
        acc && !req_untrans && req_vaddr[31:30] == 2'b11 |=> ##1
        (rsp_valid && rsp_fault == FLT_ACCESS));

    p_offset_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault == FLT_NONE && !cap_ut |->
        (rsp_addr[8:0] == cap_va[8:0] && rsp_addr[31:30] == 2'b00));

    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> (mem_req_valid && $stable(mem_req_addr)));

    p_single_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);

    p_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind region_xlate xlt_checker u_chk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_untrans(req_untrans), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr)
);

// File: tb/tb_region_xlate.sv
module tb_region_xlate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_untrans = 1'b0;
    logic        req_priv = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic [2:0]  rsp_fault;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        tlb_flush = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #5 clk = ~clk;

    region_xlate dut (.*);

    int n_chk = 0, n_fail = 0, n_reads = 0;
    bit done = 1'b0;

    // bench copies of the programmed configuration
    logic [31:0] p0b = 32'h8000_7C00, p0l = 32'd400;
    logic [31:0] p1b = 32'h8000_0F00, p1l = 32'd100;
    logic [31:0] sb  = 32'h0010_0000, sl  = 32'd64;

    function automatic logic [31:0] sys_pte(input logic [31:0] s);
        logic [20:0] f = 21'(s + 32'h1000);
        return {(s % 13) != 7, 10'b0, f};
    endfunction

    function automatic logic [31:0] leaf_pte(input logic [31:0] a);
        logic [20:0] f = 21'(a >> 2) ^ 21'h10_0000;
        return {a[6:2] != 5'd3, 10'b0, f};
    endfunction

    function automatic logic [31:0] mem_data(input logic [31:0] a);
        if (a >= sb && a < sb + 4 * sl && a[1:0] == 2'b00) return sys_pte((a - sb) >> 2);
        return leaf_pte(a);
    endfunction

    // expected response computed from the requirements
    task automatic expect_of(input logic [31:0] va, input bit ut, input bit pv,
                             output logic [2:0] f, output logic [31:0] a);
        logic [1:0]  rg = va[31:30];
        logic [31:0] v  = {11'b0, va[29:9]};
        logic [31:0] ln, bs, ptva, sv, spte, pte;
        f = 3'd0; a = va;
        if (ut) begin
            if (!pv) f = 3'd4;
            return;
        end
        if (rg == 2'd3) begin f = 3'd3; return; end
        ln = (rg == 2'd0) ? p0l : (rg == 2'd1) ? p1l : sl;
        bs = (rg == 2'd0) ? p0b : p1b;
        if (v >= ln) begin f = 3'd1; return; end
        if (rg == 2'd2) begin
            pte = mem_data(sb + 4 * v);
            if (!pte[31]) f = 3'd2;
            else a = {2'b00, pte[20:0], va[8:0]};
            return;
        end
        ptva = bs + 4 * v;
        a = ptva;
        if (ptva[31:30] != 2'b10) begin f = 3'd3; return; end
        sv = {11'b0, ptva[29:9]};
        if (sv >= sl) begin f = 3'd1; return; end
        spte = mem_data(sb + 4 * sv);
        if (!spte[31]) begin f = 3'd2; return; end
        pte = mem_data({2'b00, spte[20:0], ptva[8:0]});
        a = va;
        if (!pte[31]) begin f = 3'd2; return; end
        a = {2'b00, pte[20:0], va[8:0]};
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: ready alternates, data returned one cycle after acceptance
    initial begin
        bit took = 1'b0;
        logic [31:0] held = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (took) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_data(held);
                took = 1'b0;
            end
            mem_req_ready = ~mem_req_ready;
            if (mem_req_valid && mem_req_ready) begin
                held = mem_req_addr;
                took = 1'b1;
                n_reads++;
            end
        end
    end

    task automatic cfg_write(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic flush_tlb();
        @(negedge clk);
        tlb_flush = 1'b1;
        @(negedge clk);
        tlb_flush = 1'b0;
    endtask

    task automatic xlate(input logic [31:0] va, input bit ut, input bit pv,
                         output logic [2:0] f, output logic [31:0] a,
                         output int lat, output int reads);
        int r0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        r0 = n_reads;
        req_valid = 1'b1; req_vaddr = va; req_untrans = ut; req_priv = pv;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        f = rsp_fault; a = rsp_addr; reads = n_reads - r0;
    endtask

    task automatic run_one(input logic [31:0] va, input bit ut, input bit pv, input string req);
        logic [2:0] f, ef;
        logic [31:0] a, ea;
        int lat, rd;
        xlate(va, ut, pv, f, a, lat, rd);
        expect_of(va, ut, pv, ef, ea);
        check(f == ef, req, $sformatf("fault for va %h", va), 32'(f), 32'(ef));
        check(a == ea, req, $sformatf("addr for va %h", va), a, ea);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] f;
        logic [31:0] a;
        int lat, rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R12)
        check(req_ready == 1'b1, "R12", "req_ready after reset", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 32'(rsp_valid), 0);
        check(mem_req_valid == 1'b0, "R12", "mem_req_valid after reset", 32'(mem_req_valid), 0);

        // R13: program the register map
        cfg_write(3'd0, p0b); cfg_write(3'd1, p0l);
        cfg_write(3'd2, p1b); cfg_write(3'd3, p1l);
        cfg_write(3'd4, sb);  cfg_write(3'd5, sl);
        cfg_write(3'd6, 32'hFFFF_FFFF); cfg_write(3'd7, 32'hFFFF_FFFF);

        // R1: privileged pass-through, even with reserved region bits
        xlate(32'hDEAD_BEEF, 1'b1, 1'b1, f, a, lat, rd);
        check(f == 3'd0 && a == 32'hDEAD_BEEF, "R1", "pass-through addr", a, 32'hDEAD_BEEF);
        check(lat == 2, "R1", "pass-through latency", 32'(lat), 2);
        check(rd == 0, "R1", "pass-through reads", 32'(rd), 0);
        // R2: unprivileged pass-through
        xlate(32'h1234_5678, 1'b1, 1'b0, f, a, lat, rd);
        check(f == 3'd4, "R2", "protection fault", 32'(f), 4);
        check(a == 32'h1234_5678, "R2", "protection addr", a, 32'h1234_5678);
        // R3: reserved region
        xlate(32'hC000_1234, 1'b0, 1'b1, f, a, lat, rd);
        check(f == 3'd3 && rd == 0, "R3", "reserved region fault/reads", {f, 29'(rd)}, {3'd3, 29'd0});
        // R4: system page at the length bound
        xlate({2'b10, 21'd64, 9'h044}, 1'b0, 1'b0, f, a, lat, rd);
        check(f == 3'd1 && rd == 0, "R4", "length fault/reads", {f, 29'(rd)}, {3'd1, 29'd0});

        // R5/R7: system region sweep over and past the length
        for (int v = 0; v < 70; v++)
            run_one({2'b10, 21'(v), 9'((v * 37) & 9'h1FF)}, 1'b0, 1'b0, "R5");
        // R6/R7/R11: region A sweep crossing valid, out-of-length system pages and own length
        for (int v = 0; v < 420; v += 5)
            run_one({2'b00, 21'(v), 9'((v * 53) & 9'h1FF)}, 1'b0, 1'b0, "R6");
        // R7: region B table straddles an invalid then a valid system page
        for (int v = 0; v < 110; v += 3)
            run_one({2'b01, 21'(v), 9'((v * 11) & 9'h1FF)}, 1'b0, 1'b0, "R7");

        // R6: entry address outside system space
        p1b = 32'h4000_0000; cfg_write(3'd2, p1b);
        xlate({2'b01, 21'd5, 9'h010}, 1'b0, 1'b0, f, a, lat, rd);
        check(f == 3'd3 && a == 32'h4000_0014, "R6", "non-system entry address", a, 32'h4000_0014);
        p1b = 32'h8000_0F00; cfg_write(3'd2, p1b);
        // R13: region B length register at select 3
        cfg_write(3'd3, 32'd0);
        xlate({2'b01, 21'd70, 9'h000}, 1'b0, 1'b0, f, a, lat, rd);
        check(f == 3'd1, "R13", "length via select 3", 32'(f), 1);
        cfg_write(3'd3, p1l);

        // R11: top frame bit reaches physical bit 29
        xlate({2'b00, 21'd1, 9'h1A5}, 1'b0, 1'b0, f, a, lat, rd);
        check(f == 3'd0 && a[29] == 1'b1, "R11", "frame bit 20", a, 32'h2000_0000 | a);

        // R9: nine distinct process fills after a flush
        flush_tlb();
        begin
            int vs [9] = '{0, 1, 2, 4, 5, 6, 8, 9, 10};
            foreach (vs[i]) begin
                xlate({2'b00, 21'(vs[i]), 9'h008}, 1'b0, 1'b0, f, a, lat, rd);
                check(rd == 2, "R9", "nested miss reads", 32'(rd), 2);
            end
        end
        xlate({2'b00, 21'd10, 9'h008}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 0, "R9", "newest fill hits", 32'(rd), 0);
        xlate({2'b00, 21'd2, 9'h008}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 0, "R9", "third fill still held", 32'(rd), 0);
        xlate({2'b00, 21'd0, 9'h008}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 2, "R9", "oldest fill evicted", 32'(rd), 2);
        // R8: hit gives the walked address with no read
        begin
            logic [2:0] ef;
            logic [31:0] ea;
            expect_of({2'b00, 21'd0, 9'h0F1}, 1'b0, 1'b0, ef, ea);
            xlate({2'b00, 21'd0, 9'h0F1}, 1'b0, 1'b0, f, a, lat, rd);
            check(rd == 0 && a == ea, "R8", "hit address", a, ea);
        end

        // R10: flush keeps system entries, drops process entries
        xlate({2'b10, 21'd40, 9'h000}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 1, "R10", "system fill reads", 32'(rd), 1);
        xlate({2'b00, 21'd12, 9'h000}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 2, "R10", "process fill reads", 32'(rd), 2);
        flush_tlb();
        xlate({2'b10, 21'd40, 9'h004}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 0, "R10", "system entry kept", 32'(rd), 0);
        check(a == {2'b00, 21'(40 + 32'h1000), 9'h004}, "R10", "system addr",
              a, {2'b00, 21'(40 + 32'h1000), 9'h004});
        xlate({2'b00, 21'd12, 9'h000}, 1'b0, 1'b0, f, a, lat, rd);
        check(rd == 2, "R10", "process entry dropped", 32'(rd), 2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule